// File: doc/BRIEF.md
# Line Shadow Pixel Counter

This block sits behind the analog-to-digital converter of a linear image sensor that looks at an object against a backlight. For every line it receives digitized pixel samples with a valid strobe and a pixel index. Only the effective imaging window is counted. The samples before the window (dummy and dark reference cells) and the samples after it are discarded. Within the window, each sample is classed as bright (lit) or dark (shadowed by the object). A sample carrying an out-of-range code cannot come from real light. Such a sample inherits the class of the sample before it.

A three-tap median over consecutive class decisions removes single-pixel glitches. The filtered decisions feed separate bright and dark counters. One cycle after the last effective pixel, a done pulse is issued. Both totals then stay on the outputs until the next line begins. The dark total is the shadowed pixel number from which software computes the object width.

Top module: `shadow_counter`

## Requirements
- R1: Only samples with `smp_valid` high and `smp_index` in FIRST_IDX to FIRST_IDX+NUM_EFF-1 are counted (61 to 5060 by default). Samples with other indices, or with `smp_valid` low, leave both counts unchanged.
- R2: A sample whose value is at or below the threshold is classed dark. A sample strictly above the threshold is classed bright.
- R3: The threshold register takes the value of `thr_value` on the clock edge where `thr_load` is high. The new value is used from the next cycle on. After reset the threshold equals THR_RESET.
- R4: For an interior effective pixel, the class that is counted is the majority of the raw classes of that pixel and its two neighbours. A single pixel that differs from two agreeing neighbours is therefore counted with its neighbours.
- R5: The first and last effective pixels of a line are counted with their own raw class, because the edge samples are replicated into the median window.
- R6: A sample value above VALID_MAX is treated as impossible. Its raw class is the raw class of the preceding effective pixel. If the impossible sample is the first effective pixel, it is classed bright.
- R7: Both counts clear when the first effective pixel of a line is accepted. When the done pulse is high, `bright_count + dark_count` equals NUM_EFF.
- R8: `line_done` is high for exactly one cycle, in the cycle after the last effective pixel is accepted. Both counts stay stable from then until the first effective pixel of the next line.
- R9: While reset is low and after it is released, both counts are zero and `line_done` is low until a line completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| thr_load | input | 1 | Load strobe for the threshold register |
| thr_value | input | SAMPLE_W | Threshold value to load |
| smp_valid | input | 1 | Sample strobe |
| smp_index | input | IDX_W | Pixel position of the sample within the line |
| smp_data | input | SAMPLE_W | Unsigned pixel sample |
| bright_count | output | CNT_W | Number of bright effective pixels in the last line |
| dark_count | output | CNT_W | Number of dark (shadowed) effective pixels in the last line |
| line_done | output | 1 | One-cycle pulse when the line totals are final |

## Verification
The bench shrinks the window to eight effective pixels starting at index 3, with a five-bit index, a reset threshold of 500 and an impossible-value limit of 16000. The sample width stays at 14 bits. At this size each line is short enough to cover every median case by hand. Those cases are a lone glitch in a run, a shadow touching either window edge, an impossible code inside a shadow and on the first pixel, and a sample exactly at the threshold. Ignored leading and trailing samples, gaps in the strobe and threshold reloads between lines are also covered, all within a few hundred cycles.

// File: rtl/ssc_pkg.sv
package ssc_pkg;

  typedef enum logic {
    PIX_BRIGHT = 1'b0,
    PIX_DARK   = 1'b1
  } pix_class_e;

  // majority of three decisions: the 3-tap median on one-bit values
  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

  // number of set bits among two strobed decisions
  function automatic logic [1:0] add_two(input logic va, input logic a,
                                         input logic vb, input logic b);
    return {1'b0, va & a} + {1'b0, vb & b};
  endfunction

endpackage

// File: rtl/ssc_window.sv
module ssc_window #(
  parameter int IDX_W     = 13,
  parameter int FIRST_IDX = 61,
  parameter int NUM_EFF   = 5000
) (
  input  logic             smp_valid,
  input  logic [IDX_W-1:0] smp_index,
  output logic             eff_hit,
  output logic             eff_first,
  output logic             eff_last
);

  localparam int LAST_IDX = FIRST_IDX + NUM_EFF - 1;

  logic [31:0] idx32;

  always_comb begin
    idx32     = 32'(smp_index);
    eff_hit   = smp_valid && (idx32 >= 32'(FIRST_IDX)) && (idx32 <= 32'(LAST_IDX));
    eff_first = smp_valid && (idx32 == 32'(FIRST_IDX));
    eff_last  = smp_valid && (idx32 == 32'(LAST_IDX));
  end

endmodule

// File: rtl/ssc_decide.sv
module ssc_decide #(
  parameter int              SAMPLE_W  = 14,
  parameter logic [SAMPLE_W-1:0] VALID_MAX = 14'h3FF0,
  parameter logic [SAMPLE_W-1:0] THR_RESET = 14'h0800
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                thr_load,
  input  logic [SAMPLE_W-1:0] thr_value,
  input  logic [SAMPLE_W-1:0] smp_data,
  input  logic                eff_first,
  input  logic                prev_dark,
  output logic [SAMPLE_W-1:0] thr_q,
  output logic                impossible,
  output logic                raw_dark
);
  import ssc_pkg::*;

  always_ff @(posedge clk) begin
    if (!rst_n)        thr_q <= THR_RESET;
    else if (thr_load) thr_q <= thr_value;
  end

  always_comb begin
    impossible = smp_data > VALID_MAX;
    if (impossible)
      raw_dark = eff_first ? logic'(PIX_BRIGHT) : prev_dark;
    else
      raw_dark = (smp_data <= thr_q) ? logic'(PIX_DARK) : logic'(PIX_BRIGHT);
  end

endmodule

// File: rtl/ssc_median.sv
module ssc_median (
  input  logic clk,
  input  logic rst_n,
  input  logic eff_hit,
  input  logic eff_first,
  input  logic eff_last,
  input  logic raw_dark,
  output logic prev_dark,
  output logic ctr_valid,
  output logic ctr_dark,
  output logic tail_valid,
  output logic tail_dark
);
  import ssc_pkg::*;

  logic p_q, pp_q, p_was_first;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      p_q         <= 1'b0;
      pp_q        <= 1'b0;
      p_was_first <= 1'b0;
    end else if (eff_hit) begin
      pp_q        <= p_q;
      p_q         <= raw_dark;
      p_was_first <= eff_first;
    end
  end

  always_comb begin
    prev_dark  = p_q;
    // the pixel before the current one is released once its right neighbour is known
    ctr_valid  = eff_hit && !eff_first;
    ctr_dark   = p_was_first ? p_q : maj3(pp_q, p_q, raw_dark);
    // the last pixel is its own median (replicated edge)
    tail_valid = eff_hit && eff_last;
    tail_dark  = raw_dark;
  end

endmodule

// File: rtl/ssc_tally.sv
module ssc_tally #(
  parameter int CNT_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             eff_hit,
  input  logic             eff_first,
  input  logic             eff_last,
  input  logic             ctr_valid,
  input  logic             ctr_dark,
  input  logic             tail_valid,
  input  logic             tail_dark,
  output logic [CNT_W-1:0] bright_q,
  output logic [CNT_W-1:0] dark_q,
  output logic             done_q
);
  import ssc_pkg::*;

  logic [1:0] add_dark, add_bright;

  always_comb begin
    add_dark   = add_two(ctr_valid, ctr_dark, tail_valid, tail_dark);
    add_bright = add_two(ctr_valid, !ctr_dark, tail_valid, !tail_dark);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bright_q <= '0;
      dark_q   <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= eff_hit && eff_last;
      if (eff_first) begin
        bright_q <= '0;
        dark_q   <= '0;
      end else if (eff_hit) begin
        bright_q <= bright_q + CNT_W'(add_bright);
        dark_q   <= dark_q + CNT_W'(add_dark);
      end
    end
  end

endmodule

// File: rtl/shadow_counter.sv
module shadow_counter #(
  parameter int              SAMPLE_W  = 14,
  parameter int              IDX_W     = 13,
  parameter int              FIRST_IDX = 61,
  parameter int              NUM_EFF   = 5000,
  parameter logic [SAMPLE_W-1:0] VALID_MAX = 14'h3FF0,
  parameter logic [SAMPLE_W-1:0] THR_RESET = 14'h0800,
  localparam int             CNT_W     = $clog2(NUM_EFF + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                thr_load,
  input  logic [SAMPLE_W-1:0] thr_value,
  input  logic                smp_valid,
  input  logic [IDX_W-1:0]    smp_index,
  input  logic [SAMPLE_W-1:0] smp_data,
  output logic [CNT_W-1:0]    bright_count,
  output logic [CNT_W-1:0]    dark_count,
  output logic                line_done
);

  // named internal events, also observed by the checker
  logic                eff_hit, eff_first, eff_last;
  logic                impossible, raw_dark, prev_dark;
  logic                ctr_valid, ctr_dark, tail_valid, tail_dark;
  logic [SAMPLE_W-1:0] thr_q;

  ssc_window #(
    .IDX_W(IDX_W), .FIRST_IDX(FIRST_IDX), .NUM_EFF(NUM_EFF)
  ) u_window (
    .smp_valid(smp_valid), .smp_index(smp_index),
    .eff_hit(eff_hit), .eff_first(eff_first), .eff_last(eff_last)
  );

  ssc_decide #(
    .SAMPLE_W(SAMPLE_W), .VALID_MAX(VALID_MAX), .THR_RESET(THR_RESET)
  ) u_decide (
    .clk(clk), .rst_n(rst_n), .thr_load(thr_load), .thr_value(thr_value),
    .smp_data(smp_data), .eff_first(eff_first), .prev_dark(prev_dark),
    .thr_q(thr_q), .impossible(impossible), .raw_dark(raw_dark)
  );

  ssc_median u_median (
    .clk(clk), .rst_n(rst_n), .eff_hit(eff_hit), .eff_first(eff_first),
    .eff_last(eff_last), .raw_dark(raw_dark), .prev_dark(prev_dark),
    .ctr_valid(ctr_valid), .ctr_dark(ctr_dark),
    .tail_valid(tail_valid), .tail_dark(tail_dark)
  );

  ssc_tally #(.CNT_W(CNT_W)) u_tally (
    .clk(clk), .rst_n(rst_n), .eff_hit(eff_hit), .eff_first(eff_first),
    .eff_last(eff_last), .ctr_valid(ctr_valid), .ctr_dark(ctr_dark),
    .tail_valid(tail_valid), .tail_dark(tail_dark),
    .bright_q(bright_count), .dark_q(dark_count), .done_q(line_done)
  );

endmodule

// File: rtl/shadow_counter_chk.sv
module shadow_counter_chk #(
  parameter int SAMPLE_W = 14,
  parameter int NUM_EFF  = 5000,
  parameter int CNT_W    = 13
) (
  input logic                clk,
  input logic                rst_n,
  input logic                thr_load,
  input logic [SAMPLE_W-1:0] thr_value,
  input logic [SAMPLE_W-1:0] thr_q,
  input logic                eff_hit,
  input logic                eff_first,
  input logic [CNT_W-1:0]    bright_count,
  input logic [CNT_W-1:0]    dark_count,
  input logic                line_done
);

  assert_sum_at_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    line_done |-> (32'(bright_count) + 32'(dark_count) == 32'(NUM_EFF)));

  assert_clear_on_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
    eff_first |=> (bright_count == '0 && dark_count == '0));

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    line_done |=> !line_done);

  assert_idle_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !eff_hit |=> ($stable(bright_count) && $stable(dark_count)));

  assert_thr_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    thr_load |=> (thr_q == $past(thr_value)));

  assert_bounded_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(bright_count) <= 32'(NUM_EFF)) && (32'(dark_count) <= 32'(NUM_EFF)));

endmodule

bind shadow_counter shadow_counter_chk #(
  .SAMPLE_W(SAMPLE_W), .NUM_EFF(NUM_EFF), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .thr_load(thr_load), .thr_value(thr_value),
  .thr_q(thr_q), .eff_hit(eff_hit), .eff_first(eff_first),
  .bright_count(bright_count), .dark_count(dark_count), .line_done(line_done)
);

// File: tb/shadow_counter_test.sv
module shadow_counter_test;

  localparam int SW = 14;
  localparam int IW = 5;
  localparam int FI = 3;
  localparam int NE = 8;
  localparam int VM = 16000;
  localparam int TR = 500;
  localparam int CW = $clog2(NE + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          thr_load = 1'b0;
  logic [SW-1:0] thr_value = '0;
  logic          smp_valid = 1'b0;
  logic [IW-1:0] smp_index = '0;
  logic [SW-1:0] smp_data = '0;
  logic [CW-1:0] bright_count, dark_count;
  logic          line_done;

  int checks = 0;
  int fails  = 0;
  int thr_model = TR;
  int line_buf[NE];
  int exp_b_q[$];
  int exp_d_q[$];
  string tag_q[$];
  int last_b, last_d;

  shadow_counter #(
    .SAMPLE_W(SW), .IDX_W(IW), .FIRST_IDX(FI), .NUM_EFF(NE),
    .VALID_MAX(SW'(VM)), .THR_RESET(SW'(TR))
  ) uut (
    .clk(clk), .rst_n(rst_n), .thr_load(thr_load), .thr_value(thr_value),
    .smp_valid(smp_valid), .smp_index(smp_index), .smp_data(smp_data),
    .bright_count(bright_count), .dark_count(dark_count), .line_done(line_done)
  );

  always #10 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary_and_end();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  task automatic load_thr(input int v);
    @(negedge clk);
    thr_load  = 1'b1;
    thr_value = SW'(v);
    @(negedge clk);
    thr_load  = 1'b0;
    thr_model = v;
  endtask

  // driver: model the expected totals, queue them, then stream the line
  task automatic run_line(input string tag);
    bit raw[NE];
    bit filt[NE];
    int nb = 0;
    int nd = 0;
    for (int k = 0; k < NE; k++) begin
      if (line_buf[k] > VM) raw[k] = (k == 0) ? 1'b0 : raw[k-1];   // R6
      else                  raw[k] = (line_buf[k] <= thr_model);   // R2
    end
    for (int k = 0; k < NE; k++) begin
      if (k == 0 || k == NE - 1) filt[k] = raw[k];                  // R5
      else filt[k] = (int'(raw[k-1]) + int'(raw[k]) + int'(raw[k+1])) >= 2; // R4
      if (filt[k]) nd++; else nb++;
    end
    exp_b_q.push_back(nb);
    exp_d_q.push_back(nd);
    tag_q.push_back(tag);
    last_b = nb;
    last_d = nd;
    for (int i = 0; i < FI + NE + 2; i++) begin
      if (i == FI + 2) begin
        // strobe gap carrying an in-window index and a dark value (R1)
        @(negedge clk);
        smp_valid = 1'b0;
        smp_index = IW'(i);
        smp_data  = '0;
      end
      @(negedge clk);
      smp_valid = 1'b1;
      smp_index = IW'(i);
      smp_data  = (i >= FI && i < FI + NE) ? SW'(line_buf[i-FI]) : SW'(0);
    end
    @(negedge clk);
    smp_valid = 1'b0;
    smp_data  = '0;
    @(negedge clk);
    // trailing and gap samples were ignored and totals held (R1, R8)
    chk({tag, " R1 bright held after trail"}, int'(bright_count), last_b);
    chk({tag, " R8 dark held after trail"}, int'(dark_count), last_d);
  endtask

  // monitor: compare totals on each done pulse
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && line_done) begin
        if (exp_b_q.size() == 0) begin
          chk("R8 unexpected done pulse", 1, 0);
        end else begin
          string t;
          int eb, ed;
          t  = tag_q.pop_front();
          eb = exp_b_q.pop_front();
          ed = exp_d_q.pop_front();
          chk({t, " bright count"}, int'(bright_count), eb);
          chk({t, " dark count"}, int'(dark_count), ed);
          chk({t, " R7 sum"}, int'(bright_count) + int'(dark_count), NE);
          @(negedge clk);
          chk({t, " R8 done one cycle"}, int'(line_done), 0);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    chk("watchdog expired", 1, 0);
    summary_and_end();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 bright in reset", int'(bright_count), 0);
    chk("R9 dark in reset", int'(dark_count), 0);
    chk("R9 done in reset", int'(line_done), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R9 done after release", int'(line_done), 0);

    line_buf = '{1000, 1000, 1000, 1000, 1000, 1000, 1000, 1000};
    run_line("R2 all bright");
    line_buf = '{500, 500, 500, 500, 500, 500, 500, 500};
    run_line("R2 equal to threshold is dark");
    line_buf = '{1000, 1000, 100, 100, 100, 100, 1000, 1000};
    run_line("R4 centered shadow");
    line_buf = '{1000, 1000, 1000, 100, 1000, 1000, 1000, 1000};
    run_line("R4 dark glitch removed");
    line_buf = '{100, 100, 1000, 100, 100, 100, 100, 100};
    run_line("R4 bright glitch removed");
    line_buf = '{100, 1000, 1000, 1000, 1000, 1000, 1000, 100};
    run_line("R5 edge pixels own class");
    line_buf = '{1000, 1000, 100, 16383, 16383, 100, 100, 100};
    run_line("R6 impossible inside shadow");
    line_buf = '{16383, 100, 100, 100, 100, 100, 100, 100};
    run_line("R6 impossible first pixel");

    load_thr(2000);
    line_buf = '{1000, 1000, 1000, 1000, 1000, 1000, 1000, 1000};
    run_line("R3 raised threshold");
    load_thr(1000);
    line_buf = '{1000, 1001, 1001, 1001, 1000, 1000, 1000, 1001};
    run_line("R3 threshold boundary");

    repeat (4) @(negedge clk);
    chk("R8 all lines reported", exp_b_q.size(), 0);
    summary_and_end();
  end

endmodule